// File: doc/BRIEF.md
# Intra Neighbour Sample Buffer for 4x4 Luma Prediction

This block stores the reconstructed edge samples that the 4x4 luma intra predictor uses as neighbours. After a 4x4 block has been reconstructed, the host writes that block's right column and bottom row in a single cycle. Before predicting the next block, the host asks for a load. The buffer then spends a fixed window of cycles gathering, one sample per cycle, everything the block needs: the four samples to its left, eight samples above it (the top row and the top-right extension), the above-left corner sample, and four availability flags.

Edge samples are kept in four small word files. Two of them are local and hold edges from blocks already coded in the current macroblock. Two are global: one holds the right edge of the previous macroblock, the other holds the bottom edge of the macroblock row above, addressed by macroblock column. The files are enabled only in the cycles that actually touch them. Blocks inside a macroblock are numbered in quad-zigzag order, and this order decides which file is read for which block.

Top module: `intra_nbr_buf`

## Requirements
- R1: After reset, ld_busy, ld_done, all four availability flags and every sample output read 0.
- R2: A load that is accepted at a clock edge keeps ld_busy high for exactly 16 cycles. ld_done is high for the single cycle after ld_busy falls. The sample files are read one sample per cycle and only while a load is in progress.
- R3: For a block that is not in the macroblock's left column, nb_left carries the right-column samples (top to bottom in lanes 0..3) of the block to its left in the same macroblock. Block index b maps to column {b[2],b[0]} and row {b[3],b[1]}.
- R4: For a block that is not in the macroblock's top row, nb_top lanes 0..3 carry the bottom-row samples (left to right) of the block above it in the same macroblock.
- R5: For a block in the left column (blocks 0, 2, 8, 10), nb_left carries the right column of the block in the same row of the previous macroblock (blocks 5, 7, 13, 15).
- R6: For a block in the top row (blocks 0, 1, 4, 5), nb_top lanes 0..3 carry the bottom row of the block in the same column (blocks 10, 11, 14, 15) of the macroblock at the same column one row up. That file holds 16 samples for each of MB_COLS columns.
- R7: av_left is 1 unless the block is in the left column of macroblock column 0. av_top is 1 unless the block is in the top row of macroblock row 0. av_corner equals av_left AND av_top.
- R8: av_tright is 1 when the 4x4 block above and to the right has already been coded and lies inside the frame. When it is 1, nb_top lanes 4..7 carry that block's bottom row. When it is 0 and av_top is 1, lanes 4..7 repeat lane 3.
- R9: A neighbour sample that is not available reads as 2^(PIX_W-1), which is 0x80 for 8-bit samples.
- R10: When av_corner is 1, nb_corner carries the bottom-right sample of the 4x4 block above and to the left.
- R11: A ld_start that arrives while ld_busy is high is ignored, and the load in progress completes with its original block and position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start | input | 1 | Request a neighbour load |
| ld_blk | input | 4 | 4x4 block index (quad-zigzag) of the block to load |
| ld_mbx | input | MBX_W | Macroblock column of the block to load |
| ld_mby | input | MBY_W | Macroblock row of the block to load |
| wr_en | input | 1 | Write the edges of a reconstructed block |
| wr_blk | input | 4 | Block index of the written block |
| wr_mbx | input | MBX_W | Macroblock column of the written block |
| wr_right | input | 4*PIX_W | Right column, lane 0 at the top |
| wr_bottom | input | 4*PIX_W | Bottom row, lane 0 at the left |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | One-cycle pulse when the outputs are complete |
| nb_left | output | 4*PIX_W | Left neighbours, lane 0 at the top |
| nb_top | output | 8*PIX_W | Top neighbours, lanes 0..3 above, 4..7 top-right |
| nb_corner | output | PIX_W | Above-left neighbour |
| av_left | output | 1 | Left neighbours available |
| av_top | output | 1 | Top neighbours available |
| av_tright | output | 1 | Top-right neighbours available |
| av_corner | output | 1 | Corner neighbour available |

## Verification
The bench builds the buffer with 8-bit samples, three macroblock columns and a two-bit row field. It walks a frame of three by three macroblocks, every block in coding order, with sample values computed from pixel coordinates. This small frame reaches, within a few thousand cycles, every global-horizontal column address, the wrap from the last column to the next row, the first-column and first-row availability cases, and the top-right of block 5 falling outside the frame on the last column. It also reaches the corner samples carried across from the previous load. One load receives a second start midway to show that the second start is ignored.

// File: rtl/intra_nbr_pkg.sv
package intra_nbr_pkg;

   // Phase of the neighbour load sequence
   typedef enum logic [2:0] {
      PH_CORNER,
      PH_LEFT,
      PH_TOP,
      PH_TRIGHT,
      PH_IDLE
   } nbr_phase_e;

   // Where the sample of the current load cycle comes from
   typedef enum logic [2:0] {
      SRC_NONE,
      SRC_FILE,
      SRC_SAVE_MB,
      SRC_SAVE_COL0,
      SRC_DUP_D
   } nbr_src_e;

   function automatic logic [1:0] blk_col(input logic [3:0] b);
      return {b[2], b[0]};
   endfunction

   function automatic logic [1:0] blk_row(input logic [3:0] b);
      return {b[3], b[1]};
   endfunction

   function automatic logic [3:0] blk_at(input logic [1:0] row, input logic [1:0] col);
      return {row[1], col[1], row[0], col[0]};
   endfunction

endpackage

// File: rtl/intra_nbr_file.sv
module intra_nbr_file #(
   parameter int PIX_W = 8,
   parameter int DEPTH = 4,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int WORD_W = 4 * PIX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              rd_en,
   input  logic [AW-1:0]     rd_addr,
   input  logic [1:0]        rd_lane,
   output logic [PIX_W-1:0]  rd_sample
);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] rd_word;

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_word;
      end
   end

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("intra_nbr_file: DEPTH must be at least 2");
      end

      if (DEPTH == (1 << AW)) begin : g_full
         assign rd_word = rd_en ? mem[rd_addr] : '0;
      end else begin : g_part
         assign rd_word = (rd_en && (rd_addr < AW'(DEPTH))) ? mem[rd_addr] : '0;

         // R6
         rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |-> (rd_addr < AW'(DEPTH)));

         // R6
         wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> (wr_addr < AW'(DEPTH)));
      end
   endgenerate

   assign rd_sample = PIX_W'(rd_word >> (int'(rd_lane) * PIX_W));

endmodule

// File: rtl/intra_nbr_seq.sv
module intra_nbr_seq
   import intra_nbr_pkg::*;
#(
   parameter int LOAD_CYCLES = 16,
   localparam int CNT_W = $clog2(LOAD_CYCLES)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   output logic       accept,
   output logic       busy,
   output logic       done,
   output nbr_phase_e phase,
   output logic [1:0] lane
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_CYCLES - 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_m1;

   generate
      if (LOAD_CYCLES < 13) begin : g_bad_len
         $error("intra_nbr_seq: a load needs at least 13 cycles");
      end
   endgenerate

   assign accept = start && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
         end else if (busy) begin
            if (cnt == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
               cnt  <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign cnt_m1 = cnt - 1'b1;
   assign lane   = cnt_m1[1:0];

   always_comb begin
      if (!busy)                     phase = PH_IDLE;
      else if (cnt == '0)            phase = PH_CORNER;
      else if (cnt <= CNT_W'(4))     phase = PH_LEFT;
      else if (cnt <= CNT_W'(8))     phase = PH_TOP;
      else if (cnt <= CNT_W'(12))    phase = PH_TRIGHT;
      else                           phase = PH_IDLE;
   end

   // R2
   load_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt == LAST) |=> (!busy && done));

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

// File: rtl/intra_nbr_avail.sv
module intra_nbr_avail
   import intra_nbr_pkg::*;
(
   input  logic [1:0] bx,
   input  logic [1:0] by,
   input  logic       mb_first_col,
   input  logic       mb_first_row,
   input  logic       mb_last_col,
   output logic       av_left,
   output logic       av_top,
   output logic       av_corner,
   output logic       av_tright
);

   logic [3:0] here_idx;
   logic [3:0] upright_idx;

   assign here_idx    = blk_at(by, bx);
   assign upright_idx = blk_at(by - 2'd1, bx + 2'd1);

   assign av_left   = (bx != 2'd0) || !mb_first_col;
   assign av_top    = (by != 2'd0) || !mb_first_row;
   assign av_corner = av_left && av_top;

   always_comb begin
      if (by == 2'd0) begin
         if (bx != 2'd3) av_tright = !mb_first_row;
         else            av_tright = !mb_first_row && !mb_last_col;
      end else begin
         av_tright = (bx != 2'd3) && (upright_idx < here_idx);
      end
   end

endmodule

// File: rtl/intra_nbr_buf.sv
module intra_nbr_buf
   import intra_nbr_pkg::*;
#(
   parameter int PIX_W       = 8,
   parameter int MB_COLS     = 40,
   parameter int MBY_W       = 8,
   parameter int LOAD_CYCLES = 16,
   localparam int MBX_W = (MB_COLS > 1) ? $clog2(MB_COLS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ld_start,
   input  logic [3:0]           ld_blk,
   input  logic [MBX_W-1:0]     ld_mbx,
   input  logic [MBY_W-1:0]     ld_mby,
   input  logic                 wr_en,
   input  logic [3:0]           wr_blk,
   input  logic [MBX_W-1:0]     wr_mbx,
   input  logic [4*PIX_W-1:0]   wr_right,
   input  logic [4*PIX_W-1:0]   wr_bottom,
   output logic                 ld_busy,
   output logic                 ld_done,
   output logic [4*PIX_W-1:0]   nb_left,
   output logic [8*PIX_W-1:0]   nb_top,
   output logic [PIX_W-1:0]     nb_corner,
   output logic                 av_left,
   output logic                 av_top,
   output logic                 av_tright,
   output logic                 av_corner
);

   localparam int LV_DEPTH = 12;
   localparam int LH_DEPTH = 4;
   localparam int GV_DEPTH = 4;
   localparam int GH_DEPTH = 4 * MB_COLS;
   localparam int LV_AW    = $clog2(LV_DEPTH);
   localparam int LH_AW    = $clog2(LH_DEPTH);
   localparam int GV_AW    = $clog2(GV_DEPTH);
   localparam int GH_AW    = $clog2(GH_DEPTH);
   localparam logic [PIX_W-1:0] DFLT = PIX_W'(1) << (PIX_W - 1);

   generate
      if (PIX_W < 2) begin : g_bad_w
         $error("intra_nbr_buf: PIX_W must be at least 2");
      end
      if (MB_COLS < 1) begin : g_bad_cols
         $error("intra_nbr_buf: MB_COLS must be at least 1");
      end
   endgenerate

   // ---------------- load sequencer ----------------
   logic       accept;
   nbr_phase_e phase;
   logic [1:0] lane;

   intra_nbr_seq #(.LOAD_CYCLES(LOAD_CYCLES)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (ld_start),
      .accept (accept),
      .busy   (ld_busy),
      .done   (ld_done),
      .phase  (phase),
      .lane   (lane)
   );

   // ---------------- availability ----------------
   logic mb_last_col;
   logic a_left, a_top, a_corner, a_tright;

   generate
      if (MB_COLS == 1) begin : g_one_col
         assign mb_last_col = 1'b1;
      end else begin : g_many_col
         assign mb_last_col = (ld_mbx == MBX_W'(MB_COLS - 1));
      end
   endgenerate

   intra_nbr_avail u_avail (
      .bx           (blk_col(ld_blk)),
      .by           (blk_row(ld_blk)),
      .mb_first_col (ld_mbx == '0),
      .mb_first_row (ld_mby == '0),
      .mb_last_col  (mb_last_col),
      .av_left      (a_left),
      .av_top       (a_top),
      .av_corner    (a_corner),
      .av_tright    (a_tright)
   );

   // ---------------- latched block position ----------------
   logic [1:0]       q_bx, q_by;
   logic [MBX_W-1:0] q_mbx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_bx      <= '0;
         q_by      <= '0;
         q_mbx     <= '0;
         av_left   <= 1'b0;
         av_top    <= 1'b0;
         av_corner <= 1'b0;
         av_tright <= 1'b0;
      end else if (accept) begin
         q_bx      <= blk_col(ld_blk);
         q_by      <= blk_row(ld_blk);
         q_mbx     <= ld_mbx;
         av_left   <= a_left;
         av_top    <= a_top;
         av_corner <= a_corner;
         av_tright <= a_tright;
      end
   end

   // ---------------- write routing ----------------
   logic [1:0]       w_bx, w_by;
   logic             lv_we, lh_we, gv_we, gh_we;
   logic [LV_AW-1:0] lv_wa;
   logic [LH_AW-1:0] lh_wa;
   logic [GV_AW-1:0] gv_wa;
   logic [GH_AW-1:0] gh_wa;

   always_comb begin
      w_bx  = blk_col(wr_blk);
      w_by  = blk_row(wr_blk);
      lv_we = wr_en && (w_bx != 2'd3);
      gv_we = wr_en && (w_bx == 2'd3);
      lh_we = wr_en && (w_by != 2'd3);
      gh_we = wr_en && (w_by == 2'd3);
      lv_wa = LV_AW'(int'(w_by) * 3 + int'(w_bx));
      gv_wa = GV_AW'(w_by);
      lh_wa = LH_AW'(w_bx);
      gh_wa = GH_AW'(int'(wr_mbx) * 4 + int'(w_bx));
   end

   // ---------------- read addressing ----------------
   logic             lv_re, lh_re, gv_re, gh_re;
   logic [LV_AW-1:0] lv_ra;
   logic [LH_AW-1:0] lh_ra;
   logic [GV_AW-1:0] gv_ra;
   logic [GH_AW-1:0] gh_ra;
   logic [1:0]       rd_lane;
   nbr_src_e         src;

   always_comb begin
      lv_re   = 1'b0;
      lh_re   = 1'b0;
      gv_re   = 1'b0;
      gh_re   = 1'b0;
      lv_ra   = '0;
      lh_ra   = '0;
      gv_ra   = '0;
      gh_ra   = '0;
      rd_lane = lane;
      src     = SRC_NONE;
      case (phase)
         PH_CORNER: begin
            rd_lane = 2'd3;
            if (av_corner) begin
               if (q_bx == 2'd0) begin
                  src = (q_by == 2'd0) ? SRC_SAVE_MB : SRC_SAVE_COL0;
               end else if (q_by == 2'd0) begin
                  src   = SRC_FILE;
                  gh_re = 1'b1;
                  gh_ra = GH_AW'(int'(q_mbx) * 4 + int'(q_bx) - 1);
               end else begin
                  src   = SRC_FILE;
                  lv_re = 1'b1;
                  lv_ra = LV_AW'((int'(q_by) - 1) * 3 + int'(q_bx) - 1);
               end
            end
         end
         PH_LEFT: begin
            if (av_left) begin
               src = SRC_FILE;
               if (q_bx == 2'd0) begin
                  gv_re = 1'b1;
                  gv_ra = GV_AW'(q_by);
               end else begin
                  lv_re = 1'b1;
                  lv_ra = LV_AW'(int'(q_by) * 3 + int'(q_bx) - 1);
               end
            end
         end
         PH_TOP: begin
            if (av_top) begin
               src = SRC_FILE;
               if (q_by == 2'd0) begin
                  gh_re = 1'b1;
                  gh_ra = GH_AW'(int'(q_mbx) * 4 + int'(q_bx));
               end else begin
                  lh_re = 1'b1;
                  lh_ra = LH_AW'(q_bx);
               end
            end
         end
         PH_TRIGHT: begin
            if (av_tright) begin
               src = SRC_FILE;
               if (q_by == 2'd0) begin
                  gh_re = 1'b1;
                  if (q_bx == 2'd3) gh_ra = GH_AW'((int'(q_mbx) + 1) * 4);
                  else              gh_ra = GH_AW'(int'(q_mbx) * 4 + int'(q_bx) + 1);
               end else begin
                  lh_re = 1'b1;
                  lh_ra = LH_AW'(int'(q_bx) + 1);
               end
            end else if (av_top) begin
               src = SRC_DUP_D;
            end
         end
         default: begin
         end
      endcase
   end

   // ---------------- sample files ----------------
   logic [PIX_W-1:0] lv_s, lh_s, gv_s, gh_s;

   intra_nbr_file #(.PIX_W(PIX_W), .DEPTH(LV_DEPTH)) u_lv (
      .clk(clk), .rst_n(rst_n), .wr_en(lv_we), .wr_addr(lv_wa), .wr_word(wr_right),
      .rd_en(lv_re), .rd_addr(lv_ra), .rd_lane(rd_lane), .rd_sample(lv_s));

   intra_nbr_file #(.PIX_W(PIX_W), .DEPTH(LH_DEPTH)) u_lh (
      .clk(clk), .rst_n(rst_n), .wr_en(lh_we), .wr_addr(lh_wa), .wr_word(wr_bottom),
      .rd_en(lh_re), .rd_addr(lh_ra), .rd_lane(rd_lane), .rd_sample(lh_s));

   intra_nbr_file #(.PIX_W(PIX_W), .DEPTH(GV_DEPTH)) u_gv (
      .clk(clk), .rst_n(rst_n), .wr_en(gv_we), .wr_addr(gv_wa), .wr_word(wr_right),
      .rd_en(gv_re), .rd_addr(gv_ra), .rd_lane(rd_lane), .rd_sample(gv_s));

   intra_nbr_file #(.PIX_W(PIX_W), .DEPTH(GH_DEPTH)) u_gh (
      .clk(clk), .rst_n(rst_n), .wr_en(gh_we), .wr_addr(gh_wa), .wr_word(wr_bottom),
      .rd_en(gh_re), .rd_addr(gh_ra), .rd_lane(rd_lane), .rd_sample(gh_s));

   // ---------------- sample select and capture ----------------
   logic [PIX_W-1:0] left_q [4];
   logic [PIX_W-1:0] top_q  [8];
   logic [PIX_W-1:0] corner_q;
   logic [PIX_W-1:0] save_mb_q;
   logic [PIX_W-1:0] save_col0_q;
   logic [PIX_W-1:0] sample;

   always_comb begin
      case (src)
         SRC_FILE:      sample = lv_s | lh_s | gv_s | gh_s;
         SRC_SAVE_MB:   sample = save_mb_q;
         SRC_SAVE_COL0: sample = save_col0_q;
         SRC_DUP_D:     sample = top_q[3];
         default:       sample = DFLT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         corner_q    <= '0;
         save_mb_q   <= '0;
         save_col0_q <= '0;
      end else begin
         if (phase == PH_CORNER) corner_q <= sample;
         if (phase == PH_LEFT && lane == 2'd3 && q_bx == 2'd0 && av_left)
            save_col0_q <= sample;
         if (phase == PH_TOP && lane == 2'd3 && q_bx == 2'd3 && q_by == 2'd0 && av_top)
            save_mb_q <= sample;
      end
   end

   generate
      for (genvar k = 0; k < 4; k++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               left_q[k]  <= '0;
               top_q[k]   <= '0;
               top_q[k+4] <= '0;
            end else begin
               if (phase == PH_LEFT && lane == 2'(k))   left_q[k]  <= sample;
               if (phase == PH_TOP && lane == 2'(k))    top_q[k]   <= sample;
               if (phase == PH_TRIGHT && lane == 2'(k)) top_q[k+4] <= sample;
            end
         end
         assign nb_left[k*PIX_W +: PIX_W]     = left_q[k];
         assign nb_top[k*PIX_W +: PIX_W]      = top_q[k];
         assign nb_top[(k+4)*PIX_W +: PIX_W]  = top_q[k+4];
      end
   endgenerate

   assign nb_corner = corner_q;

   // R2
   one_file_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lv_re, lh_re, gv_re, gh_re}));

   // R2
   idle_files_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_busy |-> !(lv_re || lh_re || gv_re || gh_re));

   // R11
   hold_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_busy |=> ($stable(q_bx) && $stable(q_by) && $stable(q_mbx)));

   // R8
   tright_needs_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      av_tright |-> av_top);

   // R7
   corner_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      av_corner |-> (av_left && av_top));

endmodule

// File: tb/intra_nbr_buf_bench.sv
module intra_nbr_buf_bench;

   localparam int W    = 8;
   localparam int COLS = 3;
   localparam int ROWS = 3;
   localparam int MBXW = 2;
   localparam int MBYW = 2;

   logic            clk;
   logic            rst_n;
   logic            ld_start;
   logic [3:0]      ld_blk;
   logic [MBXW-1:0] ld_mbx;
   logic [MBYW-1:0] ld_mby;
   logic            wr_en;
   logic [3:0]      wr_blk;
   logic [MBXW-1:0] wr_mbx;
   logic [4*W-1:0]  wr_right;
   logic [4*W-1:0]  wr_bottom;
   logic            ld_busy, ld_done;
   logic [4*W-1:0]  nb_left;
   logic [8*W-1:0]  nb_top;
   logic [W-1:0]    nb_corner;
   logic            av_left, av_top, av_tright, av_corner;

   int checks = 0;
   int fails  = 0;
   bit coded [ROWS*4][COLS*4];

   intra_nbr_buf #(.PIX_W(W), .MB_COLS(COLS), .MBY_W(MBYW)) u_intra_nbr_buf (
      .clk(clk), .rst_n(rst_n),
      .ld_start(ld_start), .ld_blk(ld_blk), .ld_mbx(ld_mbx), .ld_mby(ld_mby),
      .wr_en(wr_en), .wr_blk(wr_blk), .wr_mbx(wr_mbx),
      .wr_right(wr_right), .wr_bottom(wr_bottom),
      .ld_busy(ld_busy), .ld_done(ld_done),
      .nb_left(nb_left), .nb_top(nb_top), .nb_corner(nb_corner),
      .av_left(av_left), .av_top(av_top), .av_tright(av_tright), .av_corner(av_corner)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic logic [W-1:0] pix(int x, int y);
      return W'((x * 29 + y * 53 + ((x * y) % 7) * 17 + 3) % 256);
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic do_block(int mbx, int mby, int b, bit inject);
      int bx, by, x0, y0, cx, cy, n;
      bit el, et, ec, etr;
      logic [4*W-1:0] e_left;
      logic [8*W-1:0] e_top;
      logic [W-1:0]   e_corner;
      string tl, tt;
      bx = ((b >> 2) & 1) * 2 + (b & 1);
      by = ((b >> 3) & 1) * 2 + ((b >> 1) & 1);
      x0 = mbx * 16 + bx * 4;
      y0 = mby * 16 + by * 4;
      cx = x0 / 4;
      cy = y0 / 4;
      el  = (cx > 0) && coded[cy][cx-1];
      et  = (cy > 0) && coded[cy-1][cx];
      ec  = el && et;
      etr = (cy > 0) && (cx + 1 < COLS * 4) && coded[cy-1][(cx + 1) % (COLS * 4)];
      for (int j = 0; j < 4; j++) begin
         e_left[j*W +: W]    = el ? pix(x0 - 1, y0 + j) : 8'h80;
         e_top[j*W +: W]     = et ? pix(x0 + j, y0 - 1) : 8'h80;
         e_top[(j+4)*W +: W] = etr ? pix(x0 + 4 + j, y0 - 1) :
                               (et ? pix(x0 + 3, y0 - 1) : 8'h80);
      end
      e_corner = ec ? pix(x0 - 1, y0 - 1) : 8'h80;

      @(negedge clk);
      ld_start = 1'b1;
      ld_blk   = 4'(b);
      ld_mbx   = MBXW'(mbx);
      ld_mby   = MBYW'(mby);
      @(negedge clk);
      ld_start = 1'b0;
      n = 0;
      while (ld_busy === 1'b1 && n < 100) begin
         n++;
         if (inject && n == 5) begin
            ld_start = 1'b1;
            ld_blk   = 4'd15;
            ld_mbx   = '0;
            ld_mby   = '0;
         end else begin
            ld_start = 1'b0;
         end
         @(negedge clk);
      end
      ld_start = 1'b0;

      chk("R2", "busy cycles", 64'(n), 64'd16);
      chk("R2", "done pulse", 64'(ld_done), 64'd1);
      if (inject) chk("R11", "restart ignored, busy cycles", 64'(n), 64'd16);

      tl = !el ? "R9" : (bx == 0 ? "R5" : "R3");
      tt = !et ? "R9" : (by == 0 ? "R6" : "R4");
      chk(tl, $sformatf("left mb(%0d,%0d) blk %0d", mbx, mby, b), 64'(nb_left), 64'(e_left));
      chk(tt, $sformatf("top mb(%0d,%0d) blk %0d", mbx, mby, b), 64'(nb_top[4*W-1:0]),
          64'(e_top[4*W-1:0]));
      chk("R8", $sformatf("top-right mb(%0d,%0d) blk %0d", mbx, mby, b),
          64'(nb_top[8*W-1:4*W]), 64'(e_top[8*W-1:4*W]));
      chk("R8", "top-right flag", 64'(av_tright), 64'(etr));
      chk("R10", $sformatf("corner mb(%0d,%0d) blk %0d", mbx, mby, b), 64'(nb_corner),
          64'(e_corner));
      chk("R7", "left/top/corner flags", 64'({av_left, av_top, av_corner}), 64'({el, et, ec}));

      @(negedge clk);
      wr_en  = 1'b1;
      wr_blk = 4'(b);
      wr_mbx = MBXW'(mbx);
      for (int j = 0; j < 4; j++) begin
         wr_right[j*W +: W]  = pix(x0 + 3, y0 + j);
         wr_bottom[j*W +: W] = pix(x0 + j, y0 + 3);
      end
      @(negedge clk);
      wr_en = 1'b0;
      coded[cy][cx] = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      ld_start  = 1'b0;
      ld_blk    = '0;
      ld_mbx    = '0;
      ld_mby    = '0;
      wr_en     = 1'b0;
      wr_blk    = '0;
      wr_mbx    = '0;
      wr_right  = '0;
      wr_bottom = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "busy/done", 64'({ld_busy, ld_done}), 64'd0);
      chk("R1", "flags", 64'({av_left, av_top, av_tright, av_corner}), 64'd0);
      chk("R1", "left/corner", 64'({nb_left, nb_corner}), 64'd0);
      chk("R1", "top", 64'(nb_top), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int my = 0; my < ROWS; my++) begin
         for (int mx = 0; mx < COLS; mx++) begin
            for (int b = 0; b < 16; b++) begin
               do_block(mx, my, b, (my == 1 && mx == 1 && b == 3));
            end
         end
      end
      report();
      $finish;
   end

endmodule